// File: doc/BRIEF.md
# Real-Time Interrupt Timer

This block is a timer peripheral with two free-running 32-bit counters. Each counter has its own prescaler, so the two time bases can run at different rates. Two capture channels take a snapshot of a chosen counter when a single-cycle event strobe arrives. Software can then measure the spacing between periodic events, such as audio sample-rate requests.

Four compare channels watch a selected counter and raise a sticky interrupt flag when the counter equals the compare value. On every match the channel adds a programmable increment to its own compare value. This produces a steady train of periodic interrupts without software touching the compare register. An optional digital watchdog counts down from a preload value once it is armed. It can only be stopped by a reset. Unless it is serviced with a two-word key sequence, it drives a reset request output.

All registers sit behind a single-cycle synchronous write port and a combinational read port, addressed by word index.

Top module: `rt_tick_timer`

## Requirements
- R1: While its run bit is set, counter i advances by one every TERM+1 clock cycles, where TERM is the value of its prescale terminal register. The run bit of counter i is CTRL bit i. A counter whose run bit is clear holds its value.
- R2: A write to a counter register (word 3 for counter 0, word 4 for counter 1) loads the written value on the next edge. Later increments continue from the loaded value and wrap modulo 2^32.
- R3: When capture strobe k is high at a clock edge, capture register k (word 5+k) takes the value that its source counter held in that cycle. The source counter is chosen by CTRL bit 4+k (0 selects counter 0, 1 selects counter 1).
- R4: When the selected counter equals compare register k (word 16+k), flag k is set on the next edge. On that same edge, compare register k increases by update register k (word 20+k).
- R5: Writing the flag register (word 7) with bit k set clears flag k. Zero bits have no effect. A match in the same cycle takes priority over the clear.
- R6: irq_o[k] is high exactly when flag k is set and bit k of the interrupt enable register (word 8) is set.
- R7: CTRL bit 8+k selects which counter compare channel k watches (0 selects counter 0, 1 selects counter 1).
- R8: Writing word 9 with bit 0 set enables the watchdog and loads its down-counter from the preload register (word 10). Once the watchdog is enabled, no write can disable it.
- R9: The watchdog is serviced when word 11 is written with 0x0000A35C and the next write to word 11 is 0x00005CA3. Servicing reloads the down-counter from the preload. Any other value written in between cancels the sequence.
- R10: While the watchdog is enabled, its down-counter (word 12) decreases by one each cycle. On the edge after it reads zero, wd_rst_o rises, and it stays high until reset.
- R11: After reset, the following read as zero: the control register, the prescale terminals, the counters, the captures, the update registers, the flags, the interrupt enables and the watchdog enable. The compare registers read as all ones. The watchdog preload and down-counter read as 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| cap_evt_i | input | 2 | Capture event strobes, one per capture channel |
| irq_o | output | NCMP | Compare interrupt requests |
| wd_rst_o | output | 1 | Watchdog reset request |

## Verification
The assertions take for granted that the event strobes are synchronous to clk_i. They also assume that a counter changes outside its own increment only through a write to its own word index, and that reg_addr_i never carries unknown bits while reg_wr_i is high. The stimulus drives every input on the falling edge from tasks that hold the address and data stable for the whole write cycle. Capture strobes are single-cycle pulses raised by the same tasks. Compare values are chosen a safe distance ahead of the running counters, so each match happens within the run rather than after a counter wrap.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

   localparam int DATA_W  = 32;
   localparam int REG_AW  = 5;
   localparam int NCNT    = 2;
   localparam int MAX_CMP = 4;

   // register word indices
   localparam logic [REG_AW-1:0] RA_CTRL  = 5'd0;
   localparam logic [REG_AW-1:0] RA_PRE0  = 5'd1;
   localparam logic [REG_AW-1:0] RA_CNT0  = 5'd3;
   localparam logic [REG_AW-1:0] RA_CAP0  = 5'd5;
   localparam logic [REG_AW-1:0] RA_FLAGS = 5'd7;
   localparam logic [REG_AW-1:0] RA_IRQEN = 5'd8;
   localparam logic [REG_AW-1:0] RA_WDEN  = 5'd9;
   localparam logic [REG_AW-1:0] RA_WDPRE = 5'd10;
   localparam logic [REG_AW-1:0] RA_WDKEY = 5'd11;
   localparam logic [REG_AW-1:0] RA_WDCNT = 5'd12;
   localparam logic [REG_AW-1:0] RA_CMP0  = 5'd16;
   localparam logic [REG_AW-1:0] RA_UPD0  = 5'd20;

   // control register field positions
   localparam int CTL_RUN_LSB = 0;
   localparam int CTL_SRC_LSB = 4;
   localparam int CTL_SEL_LSB = 8;

   localparam logic [DATA_W-1:0] WD_KEY_FIRST  = 32'h0000_A35C;
   localparam logic [DATA_W-1:0] WD_KEY_SECOND = 32'h0000_5CA3;

   typedef enum logic {
      KEY_IDLE,
      KEY_ARMED
   } key_state_e;

endpackage

// File: rtl/rtt_prescaled_counter.sv
module rtt_prescaled_counter #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [PRE_W-1:0] term_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [PRE_W-1:0] pc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   // terminal reached (>= guards against a terminal lowered below the count)
   assign tick = run_i && (pc_q >= term_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc_q <= '0;
      end else if (tick) begin
         pc_q <= '0;
      end else if (run_i) begin
         pc_q <= pc_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/rtt_compare_unit.sv
module rtt_compare_unit #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             cmp_wr_i,
   input  logic             upd_wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             flag_clr_i,
   output logic [CNT_W-1:0] cmp_o,
   output logic [CNT_W-1:0] upd_o,
   output logic             flag_o,
   output logic             match_o
);

   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] upd_q;
   logic             flag_q;

   assign match_o = (cnt_i == cmp_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_q  <= '1;
         upd_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (cmp_wr_i) begin
            cmp_q <= wdata_i;
         end else if (match_o) begin
            cmp_q <= cmp_q + upd_q;
         end
         if (upd_wr_i) begin
            upd_q <= wdata_i;
         end
         if (match_o) begin
            flag_q <= 1'b1;
         end else if (flag_clr_i) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign cmp_o  = cmp_q;
   assign upd_o  = upd_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/rtt_watchdog.sv
module rtt_watchdog
   import rtt_pkg::*;
#(
   parameter int WD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_wr_i,
   input  logic              pre_wr_i,
   input  logic              key_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              en_o,
   output logic [WD_W-1:0]   cnt_o,
   output logic [WD_W-1:0]   pre_o,
   output logic              expired_o
);

   key_state_e     key_q;
   logic           en_q;
   logic           exp_q;
   logic [WD_W-1:0] cnt_q;
   logic [WD_W-1:0] pre_q;
   logic           start;
   logic           service;

   assign start   = en_wr_i && wdata_i[0] && !en_q;
   assign service = key_wr_i && (key_q == KEY_ARMED) && (wdata_i == WD_KEY_SECOND);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         key_q <= KEY_IDLE;
         en_q  <= 1'b0;
         exp_q <= 1'b0;
         cnt_q <= '1;
         pre_q <= '1;
      end else begin
         if (pre_wr_i) begin
            pre_q <= wdata_i[WD_W-1:0];
         end
         if (key_wr_i) begin
            key_q <= (wdata_i == WD_KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
         end
         if (start) begin
            en_q  <= 1'b1;
            cnt_q <= pre_q;
         end else if (en_q && !exp_q) begin
            if (service) begin
               cnt_q <= pre_q;
            end else if (cnt_q == '0) begin
               exp_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign en_o      = en_q;
   assign cnt_o     = cnt_q;
   assign pre_o     = pre_q;
   assign expired_o = exp_q;

endmodule

// File: rtl/rt_tick_timer.sv
module rt_tick_timer
   import rtt_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int PRE_W      = 16,
   parameter int NCMP       = 4,
   parameter int WD_W       = 16,
   parameter bit WD_PRESENT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic [NCNT-1:0]   cap_evt_i,
   output logic [NCMP-1:0]   irq_o,
   output logic              wd_rst_o
);

   // elaboration-time parameter checks
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..DATA_W");
   end
   if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre_w
      $error("PRE_W must lie in 1..DATA_W");
   end
   if (WD_W < 1 || WD_W > DATA_W) begin : g_bad_wd_w
      $error("WD_W must lie in 1..DATA_W");
   end
   if (NCMP < 1 || NCMP > MAX_CMP) begin : g_bad_ncmp
      $error("NCMP must lie in 1..MAX_CMP");
   end

   logic [NCNT-1:0]             run_q;
   logic [NCNT-1:0]             cap_src_q;
   logic [NCMP-1:0]             cmp_sel_q;
   logic [NCMP-1:0]             irq_en_q;
   logic [NCNT-1:0][PRE_W-1:0]  term_q;
   logic [NCNT-1:0][CNT_W-1:0]  cnt_all;
   logic [NCNT-1:0][CNT_W-1:0]  cap_all;
   logic [NCMP-1:0][CNT_W-1:0]  cmp_all;
   logic [NCMP-1:0][CNT_W-1:0]  upd_all;
   logic [NCMP-1:0]             flag_all;
   logic [NCMP-1:0]             match_all;
   logic                        wd_en;
   logic [WD_W-1:0]             wd_cnt;
   logic [WD_W-1:0]             wd_pre;

   // configuration registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q     <= '0;
         cap_src_q <= '0;
         cmp_sel_q <= '0;
         irq_en_q  <= '0;
         term_q    <= '0;
      end else if (reg_wr_i) begin
         if (reg_addr_i == RA_CTRL) begin
            run_q     <= reg_wdata_i[CTL_RUN_LSB +: NCNT];
            cap_src_q <= reg_wdata_i[CTL_SRC_LSB +: NCNT];
            cmp_sel_q <= reg_wdata_i[CTL_SEL_LSB +: NCMP];
         end
         if (reg_addr_i == RA_IRQEN) begin
            irq_en_q <= reg_wdata_i[NCMP-1:0];
         end
         for (int i = 0; i < NCNT; i++) begin
            if (reg_addr_i == REG_AW'(RA_PRE0 + i)) begin
               term_q[i] <= reg_wdata_i[PRE_W-1:0];
            end
         end
      end
   end

   // counters and capture channels
   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      logic load;
      assign load = reg_wr_i && (reg_addr_i == REG_AW'(RA_CNT0 + i));

      rtt_prescaled_counter #(
         .CNT_W (CNT_W),
         .PRE_W (PRE_W)
      ) u_cnt (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .run_i      (run_q[i]),
         .term_i     (term_q[i]),
         .load_i     (load),
         .load_val_i (reg_wdata_i[CNT_W-1:0]),
         .cnt_o      (cnt_all[i])
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cap_all[i] <= '0;
         end else if (cap_evt_i[i]) begin
            cap_all[i] <= cnt_all[cap_src_q[i]];
         end
      end
   end

   // compare channels
   for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      logic [CNT_W-1:0] sel_cnt;
      logic             cmp_wr;
      logic             upd_wr;
      logic             clr;
      assign sel_cnt = cnt_all[cmp_sel_q[k]];
      assign cmp_wr  = reg_wr_i && (reg_addr_i == REG_AW'(RA_CMP0 + k));
      assign upd_wr  = reg_wr_i && (reg_addr_i == REG_AW'(RA_UPD0 + k));
      assign clr     = reg_wr_i && (reg_addr_i == RA_FLAGS) && reg_wdata_i[k];

      rtt_compare_unit #(
         .CNT_W (CNT_W)
      ) u_cmp (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .cnt_i      (sel_cnt),
         .cmp_wr_i   (cmp_wr),
         .upd_wr_i   (upd_wr),
         .wdata_i    (reg_wdata_i[CNT_W-1:0]),
         .flag_clr_i (clr),
         .cmp_o      (cmp_all[k]),
         .upd_o      (upd_all[k]),
         .flag_o     (flag_all[k]),
         .match_o    (match_all[k])
      );
   end

   assign irq_o = flag_all & irq_en_q;

   // optional watchdog
   if (WD_PRESENT) begin : g_wd
      rtt_watchdog #(
         .WD_W (WD_W)
      ) u_wd (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .en_wr_i   (reg_wr_i && (reg_addr_i == RA_WDEN)),
         .pre_wr_i  (reg_wr_i && (reg_addr_i == RA_WDPRE)),
         .key_wr_i  (reg_wr_i && (reg_addr_i == RA_WDKEY)),
         .wdata_i   (reg_wdata_i),
         .en_o      (wd_en),
         .cnt_o     (wd_cnt),
         .pre_o     (wd_pre),
         .expired_o (wd_rst_o)
      );
   end else begin : g_no_wd
      assign wd_en    = 1'b0;
      assign wd_cnt   = '0;
      assign wd_pre   = '0;
      assign wd_rst_o = 1'b0;
   end

   // read port
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         RA_CTRL: begin
            reg_rdata_o[CTL_RUN_LSB +: NCNT] = run_q;
            reg_rdata_o[CTL_SRC_LSB +: NCNT] = cap_src_q;
            reg_rdata_o[CTL_SEL_LSB +: NCMP] = cmp_sel_q;
         end
         RA_FLAGS: reg_rdata_o[NCMP-1:0] = flag_all;
         RA_IRQEN: reg_rdata_o[NCMP-1:0] = irq_en_q;
         RA_WDEN:  reg_rdata_o[0]        = wd_en;
         RA_WDPRE: reg_rdata_o[WD_W-1:0] = wd_pre;
         RA_WDCNT: reg_rdata_o[WD_W-1:0] = wd_cnt;
         default:  ;
      endcase
      for (int i = 0; i < NCNT; i++) begin
         if (reg_addr_i == REG_AW'(RA_PRE0 + i)) reg_rdata_o[PRE_W-1:0] = term_q[i];
         if (reg_addr_i == REG_AW'(RA_CNT0 + i)) reg_rdata_o[CNT_W-1:0] = cnt_all[i];
         if (reg_addr_i == REG_AW'(RA_CAP0 + i)) reg_rdata_o[CNT_W-1:0] = cap_all[i];
      end
      for (int k = 0; k < NCMP; k++) begin
         if (reg_addr_i == REG_AW'(RA_CMP0 + k)) reg_rdata_o[CNT_W-1:0] = cmp_all[k];
         if (reg_addr_i == REG_AW'(RA_UPD0 + k)) reg_rdata_o[CNT_W-1:0] = upd_all[k];
      end
   end

endmodule

// File: rtl/rtt_checker.sv
module rtt_checker
   import rtt_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int NCMP  = 4,
   parameter int WD_W  = 16
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic                       reg_wr_i,
   input logic [REG_AW-1:0]          reg_addr_i,
   input logic [NCNT-1:0]            cap_evt_i,
   input logic [NCNT-1:0]            cap_src_q,
   input logic [NCNT-1:0][CNT_W-1:0] cnt_all,
   input logic [NCNT-1:0][CNT_W-1:0] cap_all,
   input logic [NCMP-1:0]            match_all,
   input logic [NCMP-1:0]            flag_all,
   input logic                       wd_en,
   input logic [WD_W-1:0]            wd_cnt,
   input logic                       wd_rst_o
);

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt_chk
      // R1: without a direct load a counter holds or steps by exactly one
      assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !(reg_wr_i && reg_addr_i == REG_AW'(RA_CNT0 + i)) |=>
            (cnt_all[i] == $past(cnt_all[i]) || cnt_all[i] == CNT_W'($past(cnt_all[i]) + 1)));

      // R3: a strobe snapshots the selected counter of that cycle
      assert_capture_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cap_evt_i[i] |=> cap_all[i] == $past(cnt_all[cap_src_q[i]]));
   end

   for (genvar k = 0; k < NCMP; k++) begin : g_cmp_chk
      // R4: a match always leaves the flag set
      assert_match_sets_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         match_all[k] |=> flag_all[k]);

      // R5: a flag only rises after a match
      assert_flag_rise_needs_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(flag_all[k]) |-> $past(match_all[k]));
   end

   // R8: the watchdog enable never drops
   assert_wd_enable_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_en |=> wd_en);

   // R10: reset request is sticky and follows an empty down-counter
   assert_wd_rst_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_rst_o |=> wd_rst_o);

   assert_wd_rst_after_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wd_rst_o) |-> ($past(wd_cnt) == '0 && $past(wd_en)));

endmodule

bind rt_tick_timer rtt_checker #(
   .CNT_W (CNT_W),
   .NCMP  (NCMP),
   .WD_W  (WD_W)
) u_rtt_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_wr_i   (reg_wr_i),
   .reg_addr_i (reg_addr_i),
   .cap_evt_i  (cap_evt_i),
   .cap_src_q  (cap_src_q),
   .cnt_all    (cnt_all),
   .cap_all    (cap_all),
   .match_all  (match_all),
   .flag_all   (flag_all),
   .wd_en      (wd_en),
   .wd_cnt     (wd_cnt),
   .wd_rst_o   (wd_rst_o)
);

// File: tb/rt_tick_timer_tb_top.sv
`timescale 1ns/1ps
module rt_tick_timer_tb_top;

   localparam int NC = 4;
   localparam logic [31:0] K1 = 32'h0000_A35C;
   localparam logic [31:0] K2 = 32'h0000_5CA3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr;
   logic [4:0]    addr;
   logic [31:0]   wdata;
   logic [1:0]    evt;
   logic [31:0]   rdata;
   logic [NC-1:0] irq;
   logic          wdr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rt_tick_timer dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .cap_evt_i   (evt),
      .irq_o       (irq),
      .wd_rst_o    (wdr)
   );

   // behavioural reference model
   logic [1:0]  m_run, m_src;
   logic [3:0]  m_sel, m_flag, m_ien;
   logic [15:0] m_term [2];
   logic [15:0] m_pc   [2];
   logic [31:0] m_cnt  [2];
   logic [31:0] m_cap  [2];
   logic [31:0] m_cmp  [4];
   logic [31:0] m_upd  [4];
   logic        m_wden, m_armed, m_exp;
   logic [15:0] m_wdpre, m_wdcnt;

   always @(posedge clk or negedge rst_n) begin : model
      logic [31:0] oc [2];
      bit          tk [2];
      bit          mt [4];
      bit          svc;
      if (!rst_n) begin
         m_run = '0; m_src = '0; m_sel = '0; m_flag = '0; m_ien = '0;
         for (int i = 0; i < 2; i++) begin
            m_term[i] = '0; m_pc[i] = '0; m_cnt[i] = '0; m_cap[i] = '0;
         end
         for (int k = 0; k < 4; k++) begin
            m_cmp[k] = '1; m_upd[k] = '0;
         end
         m_wden = 0; m_armed = 0; m_exp = 0; m_wdpre = 16'hFFFF; m_wdcnt = 16'hFFFF;
      end else begin
         for (int i = 0; i < 2; i++) begin
            oc[i] = m_cnt[i];
            tk[i] = m_run[i] && (m_pc[i] >= m_term[i]);
         end
         for (int k = 0; k < 4; k++) mt[k] = (oc[m_sel[k]] == m_cmp[k]);
         for (int k = 0; k < 2; k++) if (evt[k]) m_cap[k] = oc[m_src[k]];
         for (int i = 0; i < 2; i++) begin
            if (tk[i]) m_pc[i] = '0;
            else if (m_run[i]) m_pc[i] = m_pc[i] + 1;
            if (wr && addr == 5'(3 + i)) m_cnt[i] = wdata;
            else if (tk[i]) m_cnt[i] = oc[i] + 1;
         end
         for (int k = 0; k < 4; k++) begin
            if (wr && addr == 5'(16 + k)) m_cmp[k] = wdata;
            else if (mt[k]) m_cmp[k] = m_cmp[k] + m_upd[k];
            if (wr && addr == 5'(20 + k)) m_upd[k] = wdata;
            if (mt[k]) m_flag[k] = 1'b1;
            else if (wr && addr == 5'd7 && wdata[k]) m_flag[k] = 1'b0;
         end
         svc = wr && addr == 5'd11 && m_armed && wdata == K2;
         if (!m_wden) begin
            if (wr && addr == 5'd9 && wdata[0]) begin
               m_wden = 1; m_wdcnt = m_wdpre;
            end
         end else if (!m_exp) begin
            if (svc) m_wdcnt = m_wdpre;
            else if (m_wdcnt == 0) m_exp = 1;
            else m_wdcnt = m_wdcnt - 1;
         end
         if (wr && addr == 5'd11) m_armed = (wdata == K1);
         if (wr && addr == 5'd10) m_wdpre = wdata[15:0];
         if (wr && addr == 5'd0) begin
            m_run = wdata[1:0]; m_src = wdata[5:4]; m_sel = wdata[11:8];
         end
         if (wr && addr == 5'd1) m_term[0] = wdata[15:0];
         if (wr && addr == 5'd2) m_term[1] = wdata[15:0];
         if (wr && addr == 5'd8) m_ien = wdata[3:0];
      end
   end

   function automatic logic [31:0] mread(input logic [4:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         5'd0: begin r[1:0] = m_run; r[5:4] = m_src; r[11:8] = m_sel; end
         5'd1: r[15:0] = m_term[0];
         5'd2: r[15:0] = m_term[1];
         5'd3: r = m_cnt[0];
         5'd4: r = m_cnt[1];
         5'd5: r = m_cap[0];
         5'd6: r = m_cap[1];
         5'd7: r[3:0] = m_flag;
         5'd8: r[3:0] = m_ien;
         5'd9: r[0] = m_wden;
         5'd10: r[15:0] = m_wdpre;
         5'd12: r[15:0] = m_wdcnt;
         5'd16, 5'd17, 5'd18, 5'd19: r = m_cmp[a - 5'd16];
         5'd20, 5'd21, 5'd22, 5'd23: r = m_upd[a - 5'd20];
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input string tag);
      @(negedge clk);
      wr = 1'b0; addr = a;
      #1;
      check(rdata, mread(a), tag);
   endtask

   task automatic rdx(input logic [4:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      wr = 1'b0; addr = a;
      #1;
      check(rdata, exp, tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [1:0] m);
      @(negedge clk);
      evt = m;
      @(negedge clk);
      evt = 2'b00;
   endtask

   // per-cycle comparison of the outputs against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({28'b0, irq}, {28'b0, m_flag & m_ien}, "R6 irq_o");
         check({31'b0, wdr}, {31'b0, m_exp}, "R10 wd_rst_o");
      end
   end

   initial begin : watchdog_timer
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog timeout actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] snap;
      rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; evt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      for (int a = 0; a < 24; a++) rd(5'(a), "R11 reset map");
      rdx(5'd16, 32'hFFFF_FFFF, "R11 compare reset");
      rdx(5'd12, 32'h0000_FFFF, "R11 watchdog count reset");
      rdx(5'd3,  32'h0, "R11 counter reset");

      // R1 prescaled counting, both counters running
      wreg(5'd1, 32'd2);
      wreg(5'd2, 32'd0);
      wreg(5'd0, 32'h0000_0623);
      idle(20);
      rd(5'd3, "R1 counter0 prescale 2");
      rd(5'd4, "R1 counter1 prescale 0");

      // R2 direct load and wrap
      wreg(5'd4, 32'hFFFF_FFF8);
      idle(12);
      rd(5'd4, "R2 load and wrap");

      // R3 captures, then swapped sources
      pulse(2'b11);
      rd(5'd5, "R3 capture0");
      rd(5'd6, "R3 capture1");
      wreg(5'd0, 32'h0000_0613);
      pulse(2'b01);
      rd(5'd5, "R3 capture0 source swap");
      rd(5'd6, "R3 capture1 held");

      // R4/R7 compare channels with auto-update
      wreg(5'd8, 32'h3);
      wreg(5'd20, 32'd3);
      wreg(5'd21, 32'd7);
      wreg(5'd22, 32'd0);
      wreg(5'd23, 32'd2);
      wreg(5'd16, mread(5'd3) + 32'd4);
      wreg(5'd17, mread(5'd4) + 32'd20);
      wreg(5'd18, mread(5'd4) + 32'd10);
      wreg(5'd19, mread(5'd3) + 32'd3);
      idle(60);
      rd(5'd7, "R4 flags after matches");
      rdx(5'd7, 32'hF, "R4 all four flags set");
      rd(5'd16, "R4 auto-update channel0");
      rd(5'd17, "R7 channel1 on counter1");
      rd(5'd18, "R4 zero update holds");
      rd(5'd19, "R7 channel3 on counter0");

      // R5 write-one-to-clear
      wreg(5'd7, 32'h5);
      rd(5'd7, "R5 clear bits 0 and 2");
      wreg(5'd7, 32'h0);
      rd(5'd7, "R5 zero write keeps flags");
      wreg(5'd8, 32'hC);
      idle(4);
      rd(5'd8, "R6 enable mask");

      // R1 halted counters hold
      wreg(5'd0, 32'h0000_0610);
      snap = mread(5'd3);
      idle(10);
      rdx(5'd3, snap, "R1 halted counter holds");
      rd(5'd4, "R1 halted counter1");

      // watchdog
      wreg(5'd10, 32'd30);
      wreg(5'd9, 32'd1);
      rd(5'd9, "R8 enabled");
      for (int n = 0; n < 3; n++) begin
         idle(10);
         wreg(5'd11, K1);
         wreg(5'd11, K2);
         rd(5'd12, "R9 serviced reload");
      end
      wreg(5'd11, K1);
      wreg(5'd11, 32'h0000_1234);
      wreg(5'd11, K2);
      rd(5'd12, "R9 broken sequence no reload");
      wreg(5'd9, 32'd0);
      rdx(5'd9, 32'd1, "R8 cannot disable");
      check({31'b0, wdr}, 32'd0, "R10 not yet expired");
      idle(45);
      rd(5'd12, "R10 down-counter at zero");
      check({31'b0, wdr}, 32'd1, "R10 reset request raised");
      idle(5);
      check({31'b0, wdr}, 32'd1, "R10 reset request sticky");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule